// File: doc/BRIEF.md
# Two-Wire Slave Register Access Port

This block is a slave on a two-wire serial bus (I2C compatible) that lets a bus master read and write an 8-bit-addressed register space held elsewhere in the chip. It oversamples the clock and data lines with the system clock, removes short spikes, recognises START, repeated START and STOP, and answers its own 7-bit device address. The upper six address bits are fixed at binary 011100. The lowest bit comes from a strap pin, so two copies can share one bus. The data line is never driven high: the block only asserts an output enable that pulls the line low.

The first byte after a write-direction address is a command byte that sets an internal register pointer. Every later byte in the same transfer is data for the register under the pointer. A read-direction transfer streams bytes starting at the stored pointer. The pointer steps by one after every data byte moved in either direction, but once it reaches 0x7F it stays there.

Toward the register space the block has a one-cycle write strobe and a read port. The read port presents the pointer as the read address and takes the read data back in the same cycle. It also pulses a read strobe when a byte is latched for transmission, so that registers which clear when read can respond. Neither port can apply back-pressure, because the bus clock cannot be stretched. The register space must accept a write strobe in any cycle and must return read data in the cycle of the strobe.

Top module: `twi_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {011100, strap}. On any other address it leaves SDA released for the acknowledge bit and for every later bit, and makes no register access until the next START or STOP.
- R2: In a write-direction transfer, the first byte after the address is acknowledged and loads the register pointer, without a write strobe.
- R3: A write transfer that stops right after the command byte leaves the new pointer in place and produces no register access. A following read then starts at that pointer.
- R4: Each data byte in a write transfer produces exactly one single-cycle write strobe, carrying the pointer as address and the byte as data. The pointer then advances by one.
- R5: The pointer does not advance past 0x7F. A read or write at 0x7F leaves it at 0x7F.
- R6: A read-direction transfer returns bytes MSB first, starting at the stored pointer. Each byte is fetched with a single-cycle read strobe carrying its address, after which the pointer advances.
- R7: When the master NACKs a read byte, the slave releases SDA and fetches no further byte before the next START.
- R8: Data bytes aimed at addresses 0x08 and 0x0C are acknowledged and advance the pointer, but produce no write strobe.
- R9: A repeated START, even in the middle of a byte, abandons that byte and restarts address reception, and the stored pointer is kept.
- R10: A pulse shorter than FILT_LEN system-clock cycles on SCL or SDA has no effect. It cannot clock a bit, and it cannot form a START or STOP.
- R11: The slave changes its SDA drive only while the filtered SCL is low.
- R12: After reset the slave releases SDA, makes no register access, and the pointer reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_lsb_i | input | 1 | Strap giving the lowest device-address bit |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | 8 | Current register pointer, used as read address |
| rd_data_i | input | 8 | Read data for rd_addr_o, valid in the same cycle |
| rd_strobe_o | output | 1 | One-cycle pulse when the byte at rd_addr_o is latched for sending |

## Verification
Two things can land on one clock edge: the read fetch of a byte and the pointer saturation at 0x7F. When the byte at 0x7F is latched, the same edge must hold the pointer instead of stepping it. The bench provokes this with a three-byte write starting at 0x7E, and then a three-byte read from 0x7E. It expects 0x7E, then 0x7F twice, on both the write and the read side, and a pointer of 0x7F afterwards. The checker also watches that every strobe at 0x7F is followed by a pointer still at 0x7F.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN,
    ST_IGNORE
  } twi_state_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b011100;
  localparam logic [7:0] PTR_SAT     = 8'h7F;
  localparam logic [7:0] RO_KEY_DEB  = 8'h08;
  localparam logic [7:0] RO_KEY_PRS  = 8'h0C;

  function automatic logic is_read_only(input logic [7:0] a);
    return (a == RO_KEY_DEB) || (a == RO_KEY_PRS);
  endfunction

  function automatic logic [7:0] ptr_after(input logic [7:0] a);
    return (a == PTR_SAT) ? a : a + 8'd1;
  endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sample;

  assign sample = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sample != line_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          line_o <= sample;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = !scl_q && scl_f;
  assign scl_fall  = scl_q && !scl_f;
  assign start_det = scl_q && scl_f && sda_q && !sda_f;
  assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/twi_ptr_unit.sv
module twi_ptr_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  output logic [7:0] ptr_o
);
  import twi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_o <= 8'h00;
    else if (load) ptr_o <= load_val;
    else if (step) ptr_o <= ptr_after(ptr_o);
  end
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_lsb_i,
  output logic       sda_oe_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i,
  output logic       rd_strobe_o
);
  import twi_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    twi_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  twi_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_state_e state_q;
  logic [3:0] bitcnt_q;
  logic [6:0] rx_sh_q;
  logic [7:0] tx_sh_q;
  logic       rw_q, cmd_seen_q, ack_drv_q, more_q;
  logic [7:0] ptr;

  logic [7:0] rx_byte;
  logic       bus_evt, byte_done, cmd_take, data_take, rd_load, ptr_step, addr_hit;

  always_comb begin
    rx_byte   = {rx_sh_q, sda_f};
    bus_evt   = start_det || stop_det;
    byte_done = !bus_evt && scl_rise && (bitcnt_q == 4'd7);
    addr_hit  = (rx_byte[7:1] == {DEV_ADDR_HI, addr_lsb_i});
    cmd_take  = (state_q == ST_RX) && byte_done && !cmd_seen_q;
    data_take = (state_q == ST_RX) && byte_done && cmd_seen_q;
    rd_load   = !bus_evt && scl_fall &&
                (((state_q == ST_ACK_OUT) && ack_drv_q && rw_q) ||
                 ((state_q == ST_ACK_IN) && more_q));
    ptr_step  = data_take || rd_load;
  end

  twi_ptr_unit u_ptr (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .load_val(rx_byte),
    .step(ptr_step), .ptr_o(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rw_q       <= 1'b0;
      cmd_seen_q <= 1'b0;
      ack_drv_q  <= 1'b0;
      more_q     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bitcnt_q   <= '0;
        cmd_seen_q <= 1'b0;
        ack_drv_q  <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        ack_drv_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              rx_sh_q  <= rx_byte[6:0];
              bitcnt_q <= bitcnt_q + 4'd1;
            end
            if (byte_done) begin
              bitcnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q    <= rx_byte[0];
                  state_q <= ST_ACK_OUT;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else begin
                state_q <= ST_ACK_OUT;
                if (cmd_take) cmd_seen_q <= 1'b1;
                if (data_take && !is_read_only(ptr)) begin
                  wr_valid_o <= 1'b1;
                  wr_addr_o  <= ptr;
                  wr_data_o  <= rx_byte;
                end
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              if (!ack_drv_q) begin
                ack_drv_q <= 1'b1;
              end else begin
                ack_drv_q <= 1'b0;
                bitcnt_q  <= '0;
                if (rw_q) begin
                  tx_sh_q <= rd_data_i;
                  state_q <= ST_TX;
                end else begin
                  state_q <= ST_RX;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_rise) bitcnt_q <= bitcnt_q + 4'd1;
            if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                state_q  <= ST_ACK_IN;
                bitcnt_q <= '0;
              end else begin
                tx_sh_q <= {tx_sh_q[6:0], 1'b0};
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) more_q <= !sda_f;
            if (scl_fall) begin
              if (more_q) begin
                tx_sh_q <= rd_data_i;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = ((state_q == ST_ACK_OUT) && ack_drv_q) ||
                       ((state_q == ST_TX) && !tx_sh_q[7]);
  assign rd_addr_o   = ptr;
  assign rd_strobe_o = rd_load;
endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe_o,
  input logic       wr_valid_o,
  input logic [7:0] wr_addr_o,
  input logic       rd_strobe_o,
  input logic [7:0] rd_addr_o
);
  import twi_pkg::*;

  // R4: write strobe lasts one cycle
  a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R4: pointer has already stepped past the written address
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (rd_addr_o == ((wr_addr_o == PTR_SAT) ? PTR_SAT : wr_addr_o + 8'd1)));

  // R5: saturation at 0x7F across a read fetch
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_o && rd_addr_o == PTR_SAT) |=> (rd_addr_o == PTR_SAT));

  // R6: read strobe lasts one cycle and never meets a write
  a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |=> !rd_strobe_o);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe_o && wr_valid_o));

  // R8: read-only locations never see a write strobe
  a_r8_ro_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !((wr_addr_o == RO_KEY_DEB) || (wr_addr_o == RO_KEY_PRS)));

  // R11: drive changes only while the filtered clock is low
  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_f);
endmodule

bind twi_regslave twi_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe_o(sda_oe_o),
  .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
  .rd_strobe_o(rd_strobe_o), .rd_addr_o(rd_addr_o)
);

// File: tb/tb_twi_regslave.sv
module tb_twi_regslave;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_oe, wr_valid, rd_strobe;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  twi_regslave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .addr_lsb_i(strap),
    .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_strobe_o(rd_strobe)
  );

  logic [7:0] mem [256];
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_rd_addr = 8'h00;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'hC3;
  endfunction

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (wr_valid) begin mem[wr_addr] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (rd_strobe) begin rd_cnt <= rd_cnt + 1; last_rd_addr <= rd_addr; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n * Q) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b0; wq(1); m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b, input bit gs, input bit gd);
    m_sda = b; wq(1);
    if (gs) begin
      m_scl = 1'b1; repeat (2) @(negedge clk); m_scl = 1'b0; repeat (2) @(negedge clk);
    end
    m_scl = 1'b1; wq(1);
    if (gd) begin m_sda = ~b; repeat (2) @(negedge clk); m_sda = b; end
    wq(1); m_scl = 1'b0; wq(1);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); b = sda_line; wq(1); m_scl = 1'b0; wq(1);
  endtask

  task automatic wbyte(input logic [7:0] v, input bit glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 4, glitch && i == 2);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(!ack, 1'b0, 1'b0);
  endtask

  logic [7:0] rb [4];

  task automatic read_from(input logic [7:0] p, input int n);
    logic a;
    bus_start; wbyte(8'h70, 0, a); chk(a, "R1 addr ack", a, 1);
    wbyte(p, 0, a); chk(a, "R2 cmd ack", a, 1);
    bus_start; wbyte(8'h71, 0, a); chk(a, "R1 read addr ack", a, 1);
    for (int i = 0; i < n; i++) rbyte(rb[i], i != n - 1);
    bus_stop;
  endtask

  // table: {address, byte written, expected read-back}
  localparam logic [23:0] VEC [6] = '{
    {8'h20, 8'h5A, 8'h5A}, {8'h21, 8'hA5, 8'hA5}, {8'h08, 8'hFF, 8'hCB},
    {8'h0C, 8'h11, 8'hCF}, {8'h24, 8'h3C, 8'h3C}, {8'h00, 8'h81, 8'h81}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    int w0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    chk(wr_valid == 1'b0 && rd_strobe == 1'b0, "R12 no access", {wr_valid, rd_strobe}, 0);
    chk(rd_addr == 8'h00, "R12 pointer", rd_addr, 0);

    // vector loop: R2 R4 R6 R8
    foreach (VEC[k]) begin
      w0 = wr_cnt;
      bus_start;
      wbyte(8'h70, 0, a); chk(a, "R1 addr ack", a, 1);
      wbyte(VEC[k][23:16], 0, a); chk(a, "R2 cmd ack", a, 1);
      wbyte(VEC[k][15:8], 0, a); chk(a, "R8 data ack", a, 1);
      bus_stop;
      chk(wr_cnt - w0 == ((VEC[k][23:16] == 8'h08 || VEC[k][23:16] == 8'h0C) ? 0 : 1),
          "R4/R8 write strobes", wr_cnt - w0, 1);
      chk(rd_addr == VEC[k][23:16] + 8'd1, "R8 pointer advance", rd_addr, VEC[k][23:16] + 8'd1);
      read_from(VEC[k][23:16], 1);
      chk(rb[0] == VEC[k][7:0], "R6 read back", rb[0], VEC[k][7:0]);
    end

    // R1 address mismatch
    w0 = wr_cnt;
    bus_start; wbyte(8'h74, 0, a); chk(!a, "R1 mismatch nack", a, 0);
    wbyte(8'h20, 0, a); chk(!a, "R1 ignored byte nack", a, 0);
    bus_stop;
    chk(wr_cnt == w0, "R1 no access", wr_cnt - w0, 0);
    // R1 strap
    strap = 1'b1; wq(2);
    bus_start; wbyte(8'h70, 0, a); chk(!a, "R1 strap=1 rejects 0x38", a, 0); bus_stop;
    bus_start; wbyte(8'h72, 0, a); chk(a, "R1 strap=1 accepts 0x39", a, 1);
    wbyte(8'h50, 0, a); wbyte(8'h66, 0, a); bus_stop;
    chk(mem[8'h50] == 8'h66, "R1 strap write", mem[8'h50], 8'h66);
    strap = 1'b0; wq(2);

    // R3 command-only transfer
    w0 = wr_cnt;
    bus_start; wbyte(8'h70, 0, a); wbyte(8'h22, 0, a); bus_stop;
    chk(wr_cnt == w0, "R3 no write", wr_cnt - w0, 0);
    chk(rd_addr == 8'h22, "R3 pointer stored", rd_addr, 8'h22);
    bus_start; wbyte(8'h71, 0, a); rbyte(rb[0], 1'b0); bus_stop;
    chk(rb[0] == init_val(8'h22), "R3 read at pointer", rb[0], init_val(8'h22));
    chk(last_rd_addr == 8'h22, "R6 strobe address", last_rd_addr, 8'h22);

    // R4 multi-byte write, R6/R7 multi-byte read
    w0 = wr_cnt;
    bus_start; wbyte(8'h70, 0, a); wbyte(8'h30, 0, a);
    wbyte(8'h11, 0, a); wbyte(8'h22, 0, a); wbyte(8'h33, 0, a); bus_stop;
    chk(wr_cnt - w0 == 3, "R4 three strobes", wr_cnt - w0, 3);
    chk(mem[8'h32] == 8'h33, "R4 third byte", mem[8'h32], 8'h33);
    r0 = rd_cnt;
    read_from(8'h30, 3);
    chk({rb[0], rb[1], rb[2]} == 24'h112233, "R6 burst read", {rb[0], rb[1], rb[2]}, 24'h112233);
    chk(rd_cnt - r0 == 3, "R7 no fetch after nack", rd_cnt - r0, 3);
    chk(sda_oe == 1'b0, "R7 released", sda_oe, 0);

    // R5 saturation on write and read
    bus_start; wbyte(8'h70, 0, a); wbyte(8'h7E, 0, a);
    wbyte(8'hAA, 0, a); wbyte(8'hBB, 0, a); wbyte(8'hCC, 0, a); bus_stop;
    chk(mem[8'h7F] == 8'hCC && mem[8'h7E] == 8'hAA, "R5 write saturates", mem[8'h7F], 8'hCC);
    chk(mem[8'h80] == init_val(8'h80), "R5 0x80 untouched", mem[8'h80], init_val(8'h80));
    chk(rd_addr == 8'h7F, "R5 pointer held", rd_addr, 8'h7F);
    read_from(8'h7E, 3);
    chk({rb[0], rb[1], rb[2]} == 24'hAACCCC, "R5 read saturates", {rb[0], rb[1], rb[2]}, 24'hAACCCC);
    chk(rd_addr == 8'h7F, "R5 pointer after read", rd_addr, 8'h7F);

    // R9 repeated START in the middle of a data byte
    w0 = wr_cnt;
    bus_start; wbyte(8'h70, 0, a); wbyte(8'h40, 0, a);
    send_bit(1'b1, 0, 0); send_bit(1'b0, 0, 0); send_bit(1'b1, 0, 0);
    bus_start; wbyte(8'h71, 0, a); chk(a, "R9 address after restart", a, 1);
    rbyte(rb[0], 1'b0); bus_stop;
    chk(wr_cnt == w0, "R9 aborted byte dropped", wr_cnt - w0, 0);
    chk(rb[0] == init_val(8'h40), "R9 pointer kept", rb[0], init_val(8'h40));

    // R10 spikes on SCL and SDA
    w0 = wr_cnt;
    bus_start; wbyte(8'h70, 0, a); wbyte(8'h60, 0, a);
    wbyte(8'hA5, 1, a); chk(a, "R10 byte with spikes acked", a, 1);
    bus_stop;
    chk(wr_cnt - w0 == 1 && mem[8'h60] == 8'hA5, "R10 spikes ignored", mem[8'h60], 8'hA5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule